// File: doc/BRIEF.md
# Shared-Function GPIO Port Controller

This block is an eight-pin general-purpose I/O port whose pins may also be claimed, one at a time, by an analog-to-digital converter. Software reaches four per-pin control registers through a small synchronous register bus: an output data register, a direction register, a pull-up enable register and a slew-rate enable register. From these the block derives, for every pin, the pad-control outputs: output level, output enable, pull-up enable and slew control. Pad input levels come back into the block through a two-flop synchronizer.

A per-pin converter claim input takes a pin away from the port. While a pin is claimed, its direction, pull-up and slew bits no longer reach the pad, and the data read-back for that pin shows zero if the pin is set as an input. The register contents are kept, so a pin returns to its previous setup when the claim is released.

Writes land on the clock edge that samples the write strobe. Read data is a combinational function of the address, so reads take no wait states.

Top module: `shared_io_port`

## Requirements
- R1: While reset is held and just after it, all four registers read 0 and pad output enable, pull-up and slew outputs are 0 on every pin.
- R2: The register offsets are: data 0, pull-up enable 1, slew enable 2, direction 3; each is 8 bits wide and reads back exactly what was last written.
- R3: A write presented with the strobe takes effect at the next rising clock edge; before that edge a read at the same address still returns the old value.
- R4: A data read returns, per pin, the synchronized pad level if the direction bit is 0 and the data register bit if the direction bit is 1 (for unclaimed pins).
- R5: Data register writes latch all eight bits whatever the direction; the pad output level equals the data bit on pins whose output is enabled and 0 otherwise.
- R6: The pad pull-up of an unclaimed pin follows its pull-up bit (1 = on) only while the direction bit is 0; on output pins the pull-up is off.
- R7: On a claimed pin (claim bit 1), output enable, pull-up and slew outputs are 0 whatever the register bits hold, and the register contents still read back unchanged.
- R8: On a claimed pin with direction bit 0, the data read returns 0 in that bit position regardless of the pad level.
- R9: On a claimed pin with direction bit 1, the data read returns the last written data bit.
- R10: A pad level change becomes visible in data reads exactly two rising clock edges after it is applied, and not after one.
- R11: On an unclaimed pin, the slew output equals the slew enable bit for both directions.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 2 | Register offset |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | PIN_W | Write data |
| bus_rdata | output | PIN_W | Read data, combinational from bus_addr |
| pad_in | input | PIN_W | Pad input levels |
| adc_claim | input | PIN_W | Per-pin converter claim |
| pad_out | output | PIN_W | Pad output level |
| pad_oe | output | PIN_W | Pad output enable |
| pad_pu | output | PIN_W | Pad pull-up enable |
| pad_slew | output | PIN_W | Pad slew-rate control |

## Verification
The bench builds the block with its default width of eight pins, so every bit position of each register, including both ends, is exercised by patterns such as 0xA5, 0x5A and 0x81. With that width, one claim pattern (0x3C) covers all four combinations of claim and direction across adjacent pins in a single read, which makes the converter override rules for read-back and pad controls checkable together. The synchronizer depth is fixed at two stages, so the latency check samples after one edge and again after two.

// File: rtl/shio_pkg.sv
// Package: shared types for the shared-function GPIO port.
// Assumes a four-register map selected by a two-bit offset.
package shio_pkg;

    localparam int SHIO_ADDR_W = 2;
    localparam int SHIO_NREGS  = 4;

    // Register offsets; the data view at offset 0 is special in read-back.
    typedef enum logic [SHIO_ADDR_W-1:0] {
        REG_DATA = 2'd0,
        REG_PULL = 2'd1,
        REG_SLEW = 2'd2,
        REG_DIR  = 2'd3
    } shio_reg_e;

endpackage

// File: rtl/shio_sync.sv
// Module: two-flop synchronizer for the pad input levels.
// Does: delays each pin level by two clock edges before use.
// Assumes: pads are asynchronous to clk; metastability beyond two flops is
// not analysed here.
module shio_sync #(
    parameter int PIN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PIN_W-1:0] din,
    output logic [PIN_W-1:0] dout
);

    logic [PIN_W-1:0] stage1_q;
    logic [PIN_W-1:0] stage2_q;
    logic [1:0]       warm_q;

    // Two-stage capture of the pad levels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= din;
            stage2_q <= stage1_q;
        end
    end

    // Counts edges since reset so the latency check has a full history.
    always_ff @(posedge clk) begin
        if (!rst_n)
            warm_q <= '0;
        else if (warm_q != 2'd2)
            warm_q <= warm_q + 2'd1;
    end

    assign dout = stage2_q;

    AST_SYNC_TWO_EDGES: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q == 2'd2) |-> (dout == $past(din, 2))); // R10

endmodule

// File: rtl/shio_regs.sv
// Module: register file of the port (data, pull-up, slew, direction).
// Does: latches write data into the register at the strobed offset on the
// next rising edge. All registers clear on reset.
// Assumes: one write per cycle; no byte enables.
module shio_regs
    import shio_pkg::*;
#(
    parameter int PIN_W = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [SHIO_ADDR_W-1:0] wr_addr,
    input  logic [PIN_W-1:0]       wr_data,
    output logic [PIN_W-1:0]       data_q,
    output logic [PIN_W-1:0]       pull_q,
    output logic [PIN_W-1:0]       slew_q,
    output logic [PIN_W-1:0]       dir_q
);

    logic [PIN_W-1:0] regs_q [SHIO_NREGS];

    for (genvar r = 0; r < SHIO_NREGS; r++) begin : g_reg
        // One control register, loaded when its offset is written.
        always_ff @(posedge clk) begin
            if (!rst_n)
                regs_q[r] <= '0;
            else if (wr_en && (wr_addr == SHIO_ADDR_W'(r)))
                regs_q[r] <= wr_data;
        end
    end

    assign data_q = regs_q[REG_DATA];
    assign pull_q = regs_q[REG_PULL];
    assign slew_q = regs_q[REG_SLEW];
    assign dir_q  = regs_q[REG_DIR];

    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (data_q == '0 && pull_q == '0 && slew_q == '0 && dir_q == '0)); // R1

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == REG_DIR) |=> (dir_q == $past(wr_data))); // R3

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && $past(rst_n)) |=> $stable(data_q)); // R2

endmodule

// File: rtl/shio_pad_ctrl.sv
// Module: per-pin pad control derivation.
// Does: turns register bits and converter claims into pad output level,
// output enable, pull-up and slew controls.
// Assumes: a claimed pin's port controls are ignored but not cleared.
module shio_pad_ctrl #(
    parameter int PIN_W = 8
) (
    input  logic [PIN_W-1:0] data_q,
    input  logic [PIN_W-1:0] pull_q,
    input  logic [PIN_W-1:0] slew_q,
    input  logic [PIN_W-1:0] dir_q,
    input  logic [PIN_W-1:0] claim,
    output logic [PIN_W-1:0] pad_out,
    output logic [PIN_W-1:0] pad_oe,
    output logic [PIN_W-1:0] pad_pu,
    output logic [PIN_W-1:0] pad_slew
);

    for (genvar p = 0; p < PIN_W; p++) begin : g_pin
        logic owned;
        logic drive;
        // Port ownership and drive decision for this pin.
        always_comb begin
            owned = !claim[p];
            drive = owned && dir_q[p];
        end
        // Pad controls for this pin.
        always_comb begin
            pad_oe[p]   = drive;
            pad_out[p]  = drive && data_q[p];
            pad_pu[p]   = owned && !dir_q[p] && pull_q[p];
            pad_slew[p] = owned && slew_q[p];
        end
    end

endmodule

// File: rtl/shio_readmux.sv
// Module: read-data multiplexer.
// Does: selects the register view at the bus offset; the data view mixes
// latched data, synchronized pad levels and converter masking per pin.
// Assumes: purely combinational, zero wait states.
module shio_readmux
    import shio_pkg::*;
#(
    parameter int PIN_W = 8
) (
    input  logic [SHIO_ADDR_W-1:0] sel,
    input  logic [PIN_W-1:0]       data_q,
    input  logic [PIN_W-1:0]       pull_q,
    input  logic [PIN_W-1:0]       slew_q,
    input  logic [PIN_W-1:0]       dir_q,
    input  logic [PIN_W-1:0]       pin_lvl,
    input  logic [PIN_W-1:0]       claim,
    output logic [PIN_W-1:0]       rdata
);

    logic [PIN_W-1:0] data_view;

    for (genvar p = 0; p < PIN_W; p++) begin : g_view
        // Per-pin data read-back: outputs show latch, inputs show pad or 0.
        always_comb begin
            if (dir_q[p])
                data_view[p] = data_q[p];
            else if (claim[p])
                data_view[p] = 1'b0;
            else
                data_view[p] = pin_lvl[p];
        end
    end

    // Offset decode of the read bus.
    always_comb begin
        unique case (shio_reg_e'(sel))
            REG_DATA: rdata = data_view;
            REG_PULL: rdata = pull_q;
            REG_SLEW: rdata = slew_q;
            REG_DIR:  rdata = dir_q;
            default:  rdata = '0;
        endcase
    end

endmodule

// File: rtl/shared_io_port.sv
// Module: shared-function GPIO port top.
// Does: ties the register file, synchronizer, pad control and read mux
// together behind a simple synchronous register bus.
// Assumes: synchronous active-low reset; adc_claim is stable w.r.t. clk.
module shared_io_port
    import shio_pkg::*;
#(
    parameter int PIN_W = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [SHIO_ADDR_W-1:0] bus_addr,
    input  logic                   bus_we,
    input  logic [PIN_W-1:0]       bus_wdata,
    output logic [PIN_W-1:0]       bus_rdata,
    input  logic [PIN_W-1:0]       pad_in,
    input  logic [PIN_W-1:0]       adc_claim,
    output logic [PIN_W-1:0]       pad_out,
    output logic [PIN_W-1:0]       pad_oe,
    output logic [PIN_W-1:0]       pad_pu,
    output logic [PIN_W-1:0]       pad_slew
);

    logic [PIN_W-1:0] data_q;
    logic [PIN_W-1:0] pull_q;
    logic [PIN_W-1:0] slew_q;
    logic [PIN_W-1:0] dir_q;
    logic [PIN_W-1:0] pin_lvl;

    shio_regs #(.PIN_W(PIN_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (bus_we),
        .wr_addr (bus_addr),
        .wr_data (bus_wdata),
        .data_q  (data_q),
        .pull_q  (pull_q),
        .slew_q  (slew_q),
        .dir_q   (dir_q)
    );

    shio_sync #(.PIN_W(PIN_W)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (pad_in),
        .dout  (pin_lvl)
    );

    shio_pad_ctrl #(.PIN_W(PIN_W)) u_pad (
        .data_q   (data_q),
        .pull_q   (pull_q),
        .slew_q   (slew_q),
        .dir_q    (dir_q),
        .claim    (adc_claim),
        .pad_out  (pad_out),
        .pad_oe   (pad_oe),
        .pad_pu   (pad_pu),
        .pad_slew (pad_slew)
    );

    shio_readmux #(.PIN_W(PIN_W)) u_rmux (
        .sel     (bus_addr),
        .data_q  (data_q),
        .pull_q  (pull_q),
        .slew_q  (slew_q),
        .dir_q   (dir_q),
        .pin_lvl (pin_lvl),
        .claim   (adc_claim),
        .rdata   (bus_rdata)
    );

    AST_CLAIM_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        ((adc_claim & (pad_oe | pad_pu | pad_slew)) == '0)); // R7

    AST_PULL_ONLY_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_pu & pad_oe) == '0)); // R6

    AST_OUT_NEEDS_OE: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_out & ~pad_oe) == '0)); // R5

    AST_CLAIM_INPUT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == REG_DATA) |-> ((bus_rdata & adc_claim & ~dir_q) == '0)); // R8

    AST_RESET_PADS_OFF: assert property (@(posedge clk)
        !rst_n |=> (pad_oe == '0 && pad_pu == '0 && pad_slew == '0)); // R1

endmodule

// File: tb/sim_shared_io_port.sv
module sim_shared_io_port;

    localparam int PIN_W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [1:0]       bus_addr = '0;
    logic             bus_we = 1'b0;
    logic [PIN_W-1:0] bus_wdata = '0;
    logic [PIN_W-1:0] bus_rdata;
    logic [PIN_W-1:0] pad_in = '0;
    logic [PIN_W-1:0] adc_claim = '0;
    logic [PIN_W-1:0] pad_out;
    logic [PIN_W-1:0] pad_oe;
    logic [PIN_W-1:0] pad_pu;
    logic [PIN_W-1:0] pad_slew;

    int n_chk  = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    shared_io_port #(.PIN_W(PIN_W)) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pad_in    (pad_in),
        .adc_claim (adc_claim),
        .pad_out   (pad_out),
        .pad_oe    (pad_oe),
        .pad_pu    (pad_pu),
        .pad_slew  (pad_slew)
    );

    task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%02h expected 0x%02h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        bus_addr = a;
        #0.5;
        d = bus_rdata;
    endtask

    task automatic settle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        settle(1);
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), v);
            chk("R1 reg after reset", v, 8'h00);
        end
        chk("R1 oe", pad_oe, 8'h00);
        chk("R1 pu", pad_pu, 8'h00);
        chk("R1 slew", pad_slew, 8'h00);
    endtask

    task automatic t_regmap();
        logic [7:0] v;
        wr(2'd1, 8'hA5); wr(2'd2, 8'h3C); wr(2'd3, 8'h0F); wr(2'd0, 8'h96);
        rd(2'd1, v); chk("R2 pull offset 1", v, 8'hA5);
        rd(2'd2, v); chk("R2 slew offset 2", v, 8'h3C);
        rd(2'd3, v); chk("R2 dir offset 3", v, 8'h0F);
        chk("R11 slew out unclaimed", pad_slew, 8'h3C);
        wr(2'd3, 8'hFF);
        rd(2'd0, v); chk("R2 data offset 0", v, 8'h96);
        wr(2'd1, 8'h00); wr(2'd2, 8'h00); wr(2'd3, 8'h00); wr(2'd0, 8'h00);
    endtask

    task automatic t_write_timing();
        logic [7:0] v;
        @(negedge clk);
        bus_addr = 2'd3; bus_we = 1'b1; bus_wdata = 8'hFF;
        #0.5;
        chk("R3 read before edge", bus_rdata, 8'h00);
        chk("R3 oe before edge", pad_oe, 8'h00);
        @(negedge clk);
        bus_we = 1'b0;
        rd(2'd3, v); chk("R3 read after edge", v, 8'hFF);
        chk("R3 oe after edge", pad_oe, 8'hFF);
    endtask

    task automatic t_output();
        logic [7:0] v;
        pad_in = 8'h00;
        wr(2'd3, 8'hFF); wr(2'd0, 8'h5A);
        settle(2);
        rd(2'd0, v); chk("R4 output pins read latch", v, 8'h5A);
        chk("R5 pad_out", pad_out, 8'h5A);
    endtask

    task automatic t_input();
        logic [7:0] v;
        wr(2'd3, 8'h00);
        pad_in = 8'hC3;
        wr(2'd0, 8'h11);
        settle(2);
        rd(2'd0, v); chk("R4 input pins read pad", v, 8'hC3);
        chk("R5 no drive when input", pad_out, 8'h00);
        chk("R5 oe off when input", pad_oe, 8'h00);
        wr(2'd3, 8'hFF);
        rd(2'd0, v); chk("R5 latched while input", v, 8'h11);
        wr(2'd3, 8'hF0); wr(2'd0, 8'hAA);
        pad_in = 8'h55;
        settle(2);
        rd(2'd0, v); chk("R4 mixed directions", v, 8'hA5);
    endtask

    task automatic t_pullup();
        wr(2'd3, 8'h0F); wr(2'd1, 8'hFF);
        chk("R6 pull only on inputs", pad_pu, 8'hF0);
        wr(2'd1, 8'h50);
        chk("R6 pull follows bit", pad_pu, 8'h50);
    endtask

    task automatic t_claim();
        logic [7:0] v;
        wr(2'd3, 8'h0F); wr(2'd1, 8'hFF); wr(2'd2, 8'hFF); wr(2'd0, 8'hFF);
        pad_in = 8'hFF;
        adc_claim = 8'h3C;
        settle(2);
        chk("R7 oe masked", pad_oe, 8'h03);
        chk("R7 pu masked", pad_pu, 8'hC0);
        chk("R7 slew masked", pad_slew, 8'hC3);
        chk("R5 pad_out claimed", pad_out, 8'h03);
        rd(2'd1, v); chk("R7 pull reg kept", v, 8'hFF);
        rd(2'd0, v); chk("R8 claimed input reads 0", v, 8'hCF);
        wr(2'd0, 8'hF3);
        rd(2'd0, v); chk("R9 claimed output reads latch", v, 8'hC3);
        adc_claim = 8'h00;
        #0.5;
        chk("R7 release restores oe", pad_oe, 8'h0F);
        wr(2'd1, 8'h00); wr(2'd2, 8'h00); wr(2'd3, 8'h00);
    endtask

    task automatic t_sync();
        logic [7:0] v;
        pad_in = 8'h00;
        settle(3);
        @(negedge clk);
        pad_in = 8'h81;
        @(negedge clk);
        rd(2'd0, v); chk("R10 not after one edge", v, 8'h00);
        @(negedge clk);
        rd(2'd0, v); chk("R10 after two edges", v, 8'h81);
    endtask

    initial begin : watchdog
        #400000;
        n_chk++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin : main
        settle(3);
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_regmap();
        t_write_timing();
        t_output();
        t_input();
        t_pullup();
        t_claim();
        t_sync();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule